// File: doc/BRIEF.md
# Prescaled PWM Down-Counter Channel

This block is a single pulse-width-modulation timer channel. A shared 8-bit prescaler and a 3-bit selectable divider turn the system clock into a timer tick. A 16-bit down counter counts from a period value to zero once per period. A compare value sets how long the output stays high in each period. The channel can reload and run continuously, or run one period and stop. The output can be inverted and gated off, and a sticky flag marks the end of each period. That flag can raise an interrupt line.

Software programs the channel through a small register port. It writes a control word, a prescale value, a divider code, a period value and a compare value. It can read back every register and the live counter value. The period and compare values apply at period boundaries, so a running waveform never shows a half-updated cycle.

Register addresses are 0 control, 1 prescale, 2 divider code, 3 period, 4 compare, 5 counter (read only) and 6 flag. Control bits are bit0 run enable, bit1 mode (1 = auto-reload, 0 = one-shot), bit2 output invert, bit3 output enable and bit4 interrupt enable. The flag is bit0 of address 6. Unused read bits return zero.

Top module: `pwm_dn_channel`

## Requirements
- R1: After reset, every register reads 0, the counter reads 0, and `pwm_pin` and `irq` are low.
- R2: One timer unit lasts (P+1)·D clock cycles, where P is the prescale value and D is the divider ratio. With P = 0 no timer unit elapses and the counter holds its value.
- R3: Divider code 000 gives D = 2, 001 gives 4, 010 gives 8, 011 gives 16, and 1xx gives 1.
- R4: The counter steps down by one per timer unit, from the period value N to 0, so one period lasts N+1 units.
- R5: For a compare value M < N, the output before inversion is high for M+1 units and low for N−M units of each period, with the high part at the end of the period. If M ≥ N, the output is high for the whole period.
- R6: Writes to the period or compare register do not change the counter or the waveform of the current period. They apply when the counter next reloads.
- R7: In one-shot mode the counter stops at 0 after its zero unit, and the output before inversion is held low. Clearing and then setting the run enable restarts the counter from the period value.
- R8: A control write that changes the mode bit from 0 to 1 clears the period and compare registers to 0. A write that leaves the mode bit at 1 leaves them unchanged.
- R9: The flag is set at the end of the counter's zero unit. Writing 1 to flag bit0 clears it, and writing 0 has no effect. `irq` equals the flag AND the interrupt enable bit.
- R10: With the invert bit set, the pin carries the complement of the waveform. With the output enable bit clear, the pin is low.
- R11: Clearing the run enable holds the counter and drives the output before inversion low. Setting it reloads the counter from the period register on the next clock edge.
- R12: Address 5 returns the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pwm_pin | output | 1 | PWM output pin |
| irq | output | 1 | Period-end interrupt |

## Verification
The bench measures high and low widths between pin edges for every divider code and a non-trivial prescale value. A wrong divider decode or an off-by-one in the prescaler shows up directly as a width error. It also covers the compare boundaries M = 0 and M ≥ N. A design that compares with the wrong sense there loses a unit or glitches low once per period.

For deferred updates, the bench stops the clock chain with P = 0 and writes a new period. It then checks that the live counter neither jumps nor changes until the next reload. A design that applies writes at once would show the new value immediately.

Further tests cover one-shot halting, clearing by write-1 only, and the mode-bit rising-edge clear. A design that kept counting after one shot, cleared the flag on a write of 0, or cleared the registers on every write with mode 1 is reported.

// File: rtl/pwm_dn_pkg.sv
package pwm_dn_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CTRL_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
    localparam logic [ADDR_W-1:0] A_DSEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PERD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd6;

    // bit0 run, bit1 mode, bit2 invert, bit3 output enable, bit4 irq enable
    typedef struct packed {
        logic irq_en;
        logic oe;
        logic inv;
        logic mode;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/pwm_dn_tick.sv
module pwm_dn_tick #(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc,
    input  logic [SEL_W-1:0] dsel,
    output logic             tick
);
    localparam int unsigned DIVC_W = 5;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DIVC_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [2:0]        shift;
    logic [DIVC_W-1:0] div_last;
    logic              pre_hit;
    logic              div_hit;

    always_comb begin
        st_d     = st_q;
        shift    = dsel[SEL_W-1] ? 3'd0 : ({1'b0, dsel[1:0]} + 3'd1);
        div_last = (DIVC_W'(1) << shift) - DIVC_W'(1);
        pre_hit  = (presc != '0) && (st_q.pre >= presc);
        div_hit  = (st_q.div >= div_last);

        if (presc == '0) begin
            st_d.pre = '0;
        end else if (pre_hit) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end

        if (pre_hit) begin
            st_d.div = div_hit ? '0 : (st_q.div + DIVC_W'(1));
        end

        tick = pre_hit && div_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_dn_regs.sv
module pwm_dn_regs
    import pwm_dn_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PRE_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              flag_set,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  presc,
    output logic [SEL_W-1:0]  dsel,
    output logic [CNT_W-1:0]  perd,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag,
    output logic [CNT_W-1:0]  rdata
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [PRE_W-1:0] presc;
        logic [SEL_W-1:0] dsel;
        logic [CNT_W-1:0] perd;
        logic [CNT_W-1:0] cmp;
        logic             flag;
    } reg_st_t;

    reg_st_t st_d, st_q;
    ctrl_t   ctrl_new;

    always_comb begin
        st_d     = st_q;
        ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
        if (wr) begin
            case (addr)
                A_CTRL: begin
                    st_d.ctrl = ctrl_new;
                    if (ctrl_new.mode && !st_q.ctrl.mode) begin
                        st_d.perd = '0;
                        st_d.cmp  = '0;
                    end
                end
                A_PRESC: st_d.presc = wdata[PRE_W-1:0];
                A_DSEL:  st_d.dsel  = wdata[SEL_W-1:0];
                A_PERD:  st_d.perd  = wdata;
                A_CMP:   st_d.cmp   = wdata;
                A_FLAG: begin
                    if (wdata[0]) begin
                        st_d.flag = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (flag_set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {{(CNT_W-CTRL_W){1'b0}}, st_q.ctrl};
            A_PRESC: rdata = {{(CNT_W-PRE_W){1'b0}}, st_q.presc};
            A_DSEL:  rdata = {{(CNT_W-SEL_W){1'b0}}, st_q.dsel};
            A_PERD:  rdata = st_q.perd;
            A_CMP:   rdata = st_q.cmp;
            A_COUNT: rdata = cnt;
            A_FLAG:  rdata = {{(CNT_W-1){1'b0}}, st_q.flag};
            default: rdata = '0;
        endcase
    end

    assign ctrl  = st_q.ctrl;
    assign presc = st_q.presc;
    assign dsel  = st_q.dsel;
    assign perd  = st_q.perd;
    assign cmp   = st_q.cmp;
    assign flag  = st_q.flag;

endmodule

// File: rtl/pwm_dn_core.sv
module pwm_dn_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             autold,
    input  logic [CNT_W-1:0] perd,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             wave,
    output logic             zero_evt,
    output logic             start,
    output logic             halted
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp_l;
        logic             run_prev;
        logic             halted;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     active;

    always_comb begin
        st_d          = st_q;
        st_d.run_prev = run;
        start         = run && !st_q.run_prev;
        active        = run && !st_q.halted;
        zero_evt      = active && tick && (st_q.cnt == '0) && !start;

        if (start) begin
            st_d.cnt    = perd;
            st_d.cmp_l  = cmp;
            st_d.halted = 1'b0;
        end else if (active && tick) begin
            if (st_q.cnt == '0) begin
                if (autold) begin
                    st_d.cnt   = perd;
                    st_d.cmp_l = cmp;
                end else begin
                    st_d.halted = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        wave = active && (st_q.cnt <= st_q.cmp_l);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign halted = st_q.halted;

endmodule

// File: rtl/pwm_dn_channel.sv
module pwm_dn_channel
    import pwm_dn_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PRE_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pwm_pin,
    output logic              irq
);

    ctrl_t            ctrl_w;
    logic [PRE_W-1:0] presc_w;
    logic [SEL_W-1:0] dsel_w;
    logic [CNT_W-1:0] perd_w;
    logic [CNT_W-1:0] cmp_w;
    logic [CNT_W-1:0] cnt_w;
    logic             flag_w;
    logic             tick_w;
    logic             wave_w;
    logic             zero_w;
    logic             start_w;
    logic             halted_w;

    pwm_dn_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .flag_set (zero_w),
        .cnt      (cnt_w),
        .ctrl     (ctrl_w),
        .presc    (presc_w),
        .dsel     (dsel_w),
        .perd     (perd_w),
        .cmp      (cmp_w),
        .flag     (flag_w),
        .rdata    (reg_rdata)
    );

    pwm_dn_tick #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (presc_w),
        .dsel  (dsel_w),
        .tick  (tick_w)
    );

    pwm_dn_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .run      (ctrl_w.run),
        .autold   (ctrl_w.mode),
        .perd     (perd_w),
        .cmp      (cmp_w),
        .cnt      (cnt_w),
        .wave     (wave_w),
        .zero_evt (zero_w),
        .start    (start_w),
        .halted   (halted_w)
    );

    assign pwm_pin = ctrl_w.oe & (wave_w ^ ctrl_w.inv);
    assign irq     = flag_w & ctrl_w.irq_en;

endmodule

// File: rtl/pwm_dn_checks.sv
module pwm_dn_checks #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PRE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PRE_W-1:0] presc,
    input logic             tick,
    input logic             start,
    input logic             halted,
    input logic             run,
    input logic             mode,
    input logic             oe,
    input logic             inv,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] perd,
    input logic [CNT_W-1:0] cmp,
    input logic             flag,
    input logic             pin
);

    assert_stop_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (presc == '0) |-> !tick);

    assert_cnt_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> ($past(tick) || $past(start)));

    assert_zero_unit_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halted && cnt == '0 && oe && !inv) |-> pin);

    assert_halt_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (cnt == '0));

    assert_mode_rise_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode) |-> (perd == '0 && cmp == '0));

    assert_flag_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == '0 && $past(tick)));

endmodule

bind pwm_dn_channel pwm_dn_checks #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .presc  (presc_w),
    .tick   (tick_w),
    .start  (start_w),
    .halted (halted_w),
    .run    (ctrl_w.run),
    .mode   (ctrl_w.mode),
    .oe     (ctrl_w.oe),
    .inv    (ctrl_w.inv),
    .cnt    (cnt_w),
    .perd   (perd_w),
    .cmp    (cmp_w),
    .flag   (flag_w),
    .pin    (pwm_pin)
);

// File: tb/sim_pwm_dn_channel.sv
`timescale 1ns/1ps
module sim_pwm_dn_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        pwm_pin;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_dn_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_pin(pwm_pin), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk);
        while (pwm_pin !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pwm_pin !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (pwm_pin === 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (pwm_pin === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic steady(input logic lvl, input int n, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_pin !== lvl) bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic t_reset;
        int v;
        check("R1 pin", int'(pwm_pin), 0);
        check("R1 irq", int'(irq), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reg %0d", a), v, 0);
        end
    endtask

    task automatic t_stop;
        int v;
        wr(3'd3, 16'd40);
        wr(3'd0, 16'h0009);
        idle(2);
        rd(3'd5, v); check("R11 reload on enable", v, 40);
        idle(50);
        rd(3'd5, v); check("R2 prescale zero holds counter", v, 40);
    endtask

    task automatic t_duty;
        int hi, lo, v;
        wr(3'd0, 16'h000B);
        wr(3'd3, 16'd9);
        wr(3'd4, 16'd3);
        wr(3'd2, 16'd4);
        wr(3'd1, 16'd1);
        measure(hi, lo); measure(hi, lo);
        check("R5 high width", hi, 8);
        check("R4 low width", lo, 12);
        rd(3'd5, v); check("R12 counter within period", int'(v <= 9), 1);
        wr(3'd4, 16'd0);
        measure(hi, lo); measure(hi, lo);
        check("R5 compare zero high", hi, 2);
        check("R5 compare zero low", lo, 18);
        wr(3'd4, 16'd9);
        idle(60);
        steady(1'b1, 100, "R5 compare equals period always high");
        wr(3'd4, 16'd30);
        idle(60);
        steady(1'b1, 100, "R5 compare above period always high");
    endtask

    task automatic t_divider;
        int hi, lo, d;
        wr(3'd3, 16'd3);
        wr(3'd4, 16'd1);
        for (int c = 0; c < 5; c++) begin
            d = (c == 4) ? 1 : (2 << c);
            wr(3'd2, 16'(c));
            measure(hi, lo); measure(hi, lo);
            check($sformatf("R3 code %0d high", c), hi, 4 * d);
            check($sformatf("R3 code %0d low", c), lo, 4 * d);
        end
        wr(3'd2, 16'd4);
        wr(3'd1, 16'd2);
        measure(hi, lo); measure(hi, lo);
        check("R2 prescale 2 high", hi, 6);
        check("R2 prescale 2 low", lo, 6);
    endtask

    task automatic t_defer;
        int v, hi, lo;
        wr(3'd1, 16'd0);
        wr(3'd3, 16'd200);
        wr(3'd0, 16'h000A);
        wr(3'd0, 16'h000B);
        idle(2);
        rd(3'd5, v); check("R11 reload 200", v, 200);
        wr(3'd3, 16'd5);
        wr(3'd4, 16'd2);
        idle(3);
        rd(3'd5, v); check("R6 counter unchanged by period write", v, 200);
        wr(3'd1, 16'd1);
        idle(20);
        rd(3'd5, v); check("R6 old period still counting", int'(v > 5 && v < 200), 1);
        idle(500);
        rd(3'd5, v); check("R6 new period after reload", int'(v <= 5), 1);
        measure(hi, lo); measure(hi, lo);
        check("R6 new duty high", hi, 6);
        check("R6 new duty low", lo, 6);
    endtask

    task automatic t_invert;
        int hi, lo;
        wr(3'd4, 16'd1);
        idle(30);
        wr(3'd0, 16'h000F);
        measure(hi, lo); measure(hi, lo);
        check("R10 inverted high", hi, 8);
        check("R10 inverted low", lo, 4);
        wr(3'd0, 16'h0007);
        steady(1'b0, 50, "R10 output disabled low");
    endtask

    task automatic t_disable;
        int a, b;
        wr(3'd0, 16'h000A);
        rd(3'd5, a);
        idle(40);
        rd(3'd5, b);
        check("R11 counter held", b, a);
        check("R11 wave low when stopped", int'(pwm_pin), 0);
        wr(3'd0, 16'h000B);
        idle(1);
        rd(3'd5, a); check("R11 restart from period", a, 5);
    endtask

    task automatic t_oneshot;
        int v;
        wr(3'd0, 16'h0008);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'd1);
        wr(3'd6, 16'h0001);
        wr(3'd0, 16'h0009);
        idle(60);
        rd(3'd5, v); check("R7 one-shot stops at zero", v, 0);
        check("R7 one-shot output low", int'(pwm_pin), 0);
        rd(3'd6, v); check("R9 flag set at period end", v, 1);
        check("R9 irq masked", int'(irq), 0);
        idle(40);
        rd(3'd5, v); check("R7 still halted", v, 0);
        wr(3'd6, 16'h0000);
        rd(3'd6, v); check("R9 write 0 keeps flag", v, 1);
        wr(3'd0, 16'h0019);
        check("R9 irq enabled", int'(irq), 1);
        wr(3'd6, 16'h0001);
        rd(3'd6, v); check("R9 write 1 clears flag", v, 0);
        check("R9 irq cleared", int'(irq), 0);
        wr(3'd0, 16'h0008);
        wr(3'd0, 16'h0009);
        idle(1);
        rd(3'd5, v); check("R7 re-enable restarts", v, 4);
    endtask

    task automatic t_mode;
        int v;
        wr(3'd0, 16'h0008);
        wr(3'd3, 16'd50);
        wr(3'd4, 16'd20);
        wr(3'd0, 16'h000A);
        rd(3'd3, v); check("R8 mode rise clears period", v, 0);
        rd(3'd4, v); check("R8 mode rise clears compare", v, 0);
        wr(3'd3, 16'd7);
        wr(3'd0, 16'h000A);
        rd(3'd3, v); check("R8 mode kept high no clear", v, 7);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_stop;
        t_duty;
        t_divider;
        t_defer;
        t_invert;
        t_disable;
        t_oneshot;
        t_mode;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule